// File: doc/BRIEF.md
# Input Change Detection Interrupt

This block watches sixteen general-purpose pins, arranged as two groups of eight. Each pin that is set as an input is compared against a stored reference level, called the snapshot. The single interrupt flag is high whenever any input pin differs from its snapshot bit. Pins set as outputs never take part in the comparison. The flag drops by itself when every changed pin goes back to its snapshot level. It also drops when software reads the group's input register, because that read loads the present levels as the new snapshot. A write to a group's port-direction register also reloads that group's snapshot.

Each raw pin first passes through a two-stage synchronizer. Both the comparison and the snapshot load use the synchronized level. A read returns that same synchronized value, so the value software sees is the value stored as the new reference. When reset is released, the block loads the snapshot for a few cycles and holds the flag low during that time. As a result, pins held steady through reset raise no interrupt at start-up. The flag is meant to appear as a status bit of the configuration register and to drive the interrupt pin.

Top module: `chg_irq_top`

## Requirements
- R1: After reset is released, with pins held steady and all set as inputs, `irq_o` is 0 from the fourth clock edge on and `rd_data_o` equals the pin levels.
- R2: When an input pin changes, `irq_o` rises on the second rising clock edge after the change and is still 0 after the first.
- R3: A pin whose `dir_in_i` bit is 0 (output) never sets `irq_o`, whatever its level does.
- R4: When a changed input returns to its snapshot level, `irq_o` clears with no strobe, two clock edges after the return.
- R5: With `rd_stb_i[g]` high, `rd_data_o` bits 8g+7..8g show the synchronized levels in the same cycle, and the same levels become group g's snapshot on that edge. The mismatch in group g is therefore gone in the next cycle.
- R6: A read strobe for one group leaves the other group's snapshot unchanged, so a mismatch in the other group keeps `irq_o` high.
- R7: `cfg_wr_i[g]` high reloads group g's snapshot from the synchronized levels on that edge.
- R8: Setting a pin's `dir_in_i` bit from 0 to 1 while its level differs from its snapshot bit raises `irq_o` in the same cycle.
- R9: `irq_o` is the OR of both groups' masked mismatches. It stays high until the mismatch of each group has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Raw pin levels, group g on bits 8g+7..8g |
| dir_in_i | input | 16 | Per-pin direction, 1 = input, 0 = output |
| rd_stb_i | input | 2 | Input-register read strobe, one per group |
| cfg_wr_i | input | 2 | Direction-register write strobe, one per group |
| rd_data_o | output | 16 | Synchronized pin levels returned by a read |
| irq_o | output | 1 | Interrupt flag |

## Verification
A pin change reaches `irq_o` after exactly two rising edges. The bench drives at a falling edge and checks one falling edge later that the flag is still low, then one more falling edge later that it is high. The return to the snapshot level is checked with the same two-edge timing. A change of a direction bit acts within the cycle, so the bench samples it a small delay after driving. Read data is sampled while the strobe is high. The flag clearing is checked at the falling edge after the strobe's rising edge, which is the first point at which the reloaded snapshot can be seen.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  parameter int unsigned GRP_W  = 8;
  parameter int unsigned N_GRP  = 2;
  parameter int unsigned SYNC_N = 2;
endpackage

// File: rtl/chg_pin_sync.sv
module chg_pin_sync #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [N-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(N); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[N-1];
endmodule

// File: rtl/chg_group.sv
module chg_group #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] dir_i,
  input  logic         load_i,
  output logic         mis_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (load_i) snap_q <= lvl_i;
  end

  // only pins set as inputs can mismatch
  assign mis_o = |((lvl_i ^ snap_q) & dir_i);
endmodule

// File: rtl/chg_irq_top.sv
module chg_irq_top
  import chg_irq_pkg::*;
#(
  parameter int unsigned GW = GRP_W,
  parameter int unsigned NG = N_GRP,
  parameter int unsigned SN = SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GW*NG-1:0] pin_i,
  input  logic [GW*NG-1:0] dir_in_i,
  input  logic [NG-1:0]    rd_stb_i,
  input  logic [NG-1:0]    cfg_wr_i,
  output logic [GW*NG-1:0] rd_data_o,
  output logic             irq_o
);
  localparam int unsigned PW    = GW * NG;
  localparam int unsigned LIMIT = SN + 1;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [PW-1:0] pin_s;
  logic [NG-1:0] grp_mis;
  logic [CW-1:0] init_cnt_q;
  logic          done;

  chg_pin_sync #(.W(PW), .N(SN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  // snapshot tracks pins until the synchronizer holds real levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    init_cnt_q <= '0;
    else if (!done) init_cnt_q <= init_cnt_q + CW'(1);
  end
  assign done = (init_cnt_q == CW'(LIMIT));

  for (genvar g = 0; g < int'(NG); g++) begin : g_grp
    chg_group #(.W(GW)) u_grp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (pin_s[g*GW +: GW]),
      .dir_i (dir_in_i[g*GW +: GW]),
      .load_i(rd_stb_i[g] | cfg_wr_i[g] | ~done),
      .mis_o (grp_mis[g])
    );
  end

  assign rd_data_o = pin_s;
  assign irq_o     = done & (|grp_mis);
endmodule

// File: rtl/chg_irq_chk.sv
module chg_irq_chk #(
  parameter int unsigned PW = 16,
  parameter int unsigned NG = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PW-1:0] dir_in_i,
  input logic [NG-1:0] rd_stb_i,
  input logic [NG-1:0] cfg_wr_i,
  input logic [PW-1:0] pin_s,
  input logic          done,
  input logic          irq_o
);
  // R3
  irq_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|dir_in_i));

  // R5
  read_all_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && (&rd_stb_i)) |=> (!irq_o || (pin_s != $past(pin_s))));

  // R7
  cfg_all_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && (&cfg_wr_i)) |=> (!irq_o || (pin_s != $past(pin_s))));

  // R4
  irq_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && (rd_stb_i == '0) && (cfg_wr_i == '0))
      |=> (!($stable(pin_s) && $stable(dir_in_i)) || $stable(irq_o)));

  // R2
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && $past(done))
      |-> ((pin_s != $past(pin_s)) || (dir_in_i != $past(dir_in_i))));
endmodule

bind chg_irq_top chg_irq_chk #(.PW(PW), .NG(NG)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .dir_in_i(dir_in_i),
  .rd_stb_i(rd_stb_i),
  .cfg_wr_i(cfg_wr_i),
  .pin_s   (pin_s),
  .done    (done),
  .irq_o   (irq_o)
);

// File: tb/chg_irq_top_bench.sv
`timescale 1ns/1ps
module chg_irq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = 16'hA5C3;
  logic [15:0] dir = 16'hFFFF;
  logic [1:0]  rd_stb = 2'b00;
  logic [1:0]  cfg_wr = 2'b00;
  logic [15:0] rd_data;
  logic        irq;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  chg_irq_top u_chg_irq_top (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pin_i    (pin),
    .dir_in_i (dir),
    .rd_stb_i (rd_stb),
    .cfg_wr_i (cfg_wr),
    .rd_data_o(rd_data),
    .irq_o    (irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read(input int g, input logic [7:0] exp_lvl);
    rd_stb[g] = 1'b1;
    #1;
    check("R5 read data", {8'h00, rd_data[g*8 +: 8]}, {8'h00, exp_lvl});
    @(negedge clk);
    rd_stb[g] = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(4);
    check("R1 irq after reset", {15'd0, irq}, 16'd0);
    check("R1 read levels", rd_data, pin);
  endtask

  task automatic t_change_return();
    pin[3] = ~pin[3];
    edges(1);
    check("R2 irq after one edge", {15'd0, irq}, 16'd0);
    edges(1);
    check("R2 irq after two edges", {15'd0, irq}, 16'd1);
    pin[3] = ~pin[3];
    edges(1);
    check("R4 irq one edge after return", {15'd0, irq}, 16'd1);
    edges(1);
    check("R4 irq cleared by return", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_output_pin();
    dir[10] = 1'b0;
    pin[10] = ~pin[10];
    edges(3);
    check("R3 output pin ignored", {15'd0, irq}, 16'd0);
    pin[10] = ~pin[10];
    edges(2);
    pin[10] = ~pin[10];
    edges(3);
    check("R3 output pin ignored again", {15'd0, irq}, 16'd0);
    dir[10] = 1'b1;
    #1;
    check("R8 dir to input raises irq", {15'd0, irq}, 16'd1);
    @(negedge clk);
    do_read(1, pin[15:8]);
    check("R5 irq cleared by read", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_other_group();
    pin[2] = ~pin[2];
    edges(3);
    check("R6 irq raised grp0", {15'd0, irq}, 16'd1);
    do_read(1, pin[15:8]);
    check("R6 other-group read keeps irq", {15'd0, irq}, 16'd1);
    cfg_wr[0] = 1'b1;
    @(negedge clk);
    cfg_wr[0] = 1'b0;
    check("R7 cfg write clears irq", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_both_groups();
    pin[1]  = ~pin[1];
    pin[12] = ~pin[12];
    edges(3);
    check("R9 irq both groups", {15'd0, irq}, 16'd1);
    do_read(0, pin[7:0]);
    check("R9 irq after grp0 read", {15'd0, irq}, 16'd1);
    do_read(1, pin[15:8]);
    check("R9 irq after grp1 read", {15'd0, irq}, 16'd0);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_change_return();
    t_output_pin();
    t_other_group();
    t_both_groups();
    edges(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule